// File: doc/BRIEF.md
# Flash Bank Storage Model

A synthesizable model of one on-chip flash bank, organised as a parameterised number of pages of 32-bit words (the defaults give 512-word pages, i.e. 2 KB). A command port starts one of three operations: erase one page, erase the whole bank, or program a run of consecutive words. Erasing drives every bit of the region to 1. Programming ANDs the new data into the stored word, so it can only clear bits. The only way back to 1 is another erase.

A separate CPU read port returns bytes, halfwords or words from the bank. While any program or erase runs, the whole bank is locked. Reads and new commands are held off through ready signals until the operation finishes. The bank keeps a count of programs per word since that word's last erase. It raises a sticky warning when a word receives a third program. The length of each operation is set by the amount of work plus a settle time in cycles given by a parameter.

Top module: `flash_bank_model`

## Requirements
- R1: After reset busy_o, warn_o and rd_valid_o are 0, and cmd_ready_o and rd_ready_o are 1.
- R2: Command code 0 erases the page containing word address cmd_addr_i (page index = cmd_addr_i / PAGE_WORDS) to all ones. Words in other pages keep their contents.
- R3: Command code 1 sets every word of the bank to 32'hFFFFFFFF.
- R4: Command code 2 stores the bitwise AND of the supplied word and the old contents. Bits already 0 stay 0.
- R5: A program command writes cmd_len_i+1 consecutive words starting at word address cmd_addr_i. Word i of the run takes cmd_wdata_i[32*i +: 32]. No word past the run changes.
- R6: A command is accepted when cmd_valid_i and cmd_ready_o are both high. From the next cycle, busy_o stays high for exactly N + OP_CYCLES cycles, where N is PAGE_WORDS for a page erase, PAGES*PAGE_WORDS for a bank erase, or cmd_len_i+1 for a program. cmd_ready_o is low for that whole time.
- R7: rd_ready_o is low while busy_o is high. A read is accepted when rd_req_i and rd_ready_o are both high, and rd_valid_o is high in the following cycle only. A request held through an operation is therefore answered in the second cycle after busy_o falls, and it sees the contents as the operation left them.
- R8: rd_addr_i is a byte address and rd_size_i selects the width: 0 = byte, 1 = halfword, 2 or 3 = word. The address is aligned down to the access width. Byte 0 of a word is bits 7:0 (little-endian), and the result is zero-extended.
- R9: A program applied to a word that has already been programmed twice since its last erase sets warn_o. warn_o stays set until reset. Erasing a word clears its program count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Bank can accept a command |
| cmd_op_i | input | 2 | 0 page erase, 1 bank erase, 2 program, 3 no operation |
| cmd_addr_i | input | $clog2(PAGES*PAGE_WORDS) | Word address of the page or of the first programmed word |
| cmd_len_i | input | $clog2(MAX_BURST) | Programmed word count minus one |
| cmd_wdata_i | input | 32*MAX_BURST | Program data, word i in bits 32*i+31:32*i |
| busy_o | output | 1 | Program or erase in progress |
| warn_o | output | 1 | Sticky over-program warning |
| rd_req_i | input | 1 | Read request, held until accepted |
| rd_ready_o | output | 1 | Read can be accepted this cycle |
| rd_addr_i | input | $clog2(PAGES*PAGE_WORDS)+2 | Byte address |
| rd_size_i | input | 2 | Access width code |
| rd_valid_o | output | 1 | Read data valid |
| rd_rdata_o | output | 32 | Read data, zero-extended |

## Verification
The bench builds the bank with PAGES=4, PAGE_WORDS=8, MAX_BURST=4 and OP_CYCLES=3, which gives 32 words in total. With these values a full-bank erase lasts only 35 busy cycles, so its exact length can be counted. Page boundaries fall every eight words, so a page erase can be shown to stop exactly at its neighbours. A four-word program buffer lets a shorter run leave an unused slot, which the bench checks is never written. A short settle time also lets the test hold a read across an operation and time its answer against the fall of busy.

// File: rtl/flash_bank_pkg.sv
package flash_bank_pkg;
  localparam logic [1:0] OP_ERASE_PAGE = 2'd0;
  localparam logic [1:0] OP_ERASE_BANK = 2'd1;
  localparam logic [1:0] OP_PROGRAM    = 2'd2;
  localparam logic [1:0] OP_NONE       = 2'd3;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_SETTLE
  } fb_state_e;
endpackage

// File: rtl/flash_bank_array.sv
module flash_bank_array #(
  parameter int WORDS = 2048,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_erase_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [31:0]   wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [31:0]   rd_word_o,
  output logic          ovp_o
);
  logic [31:0] mem_q [WORDS];
  logic [1:0]  cnt_q [WORDS];
  logic [31:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      if (wr_erase_i) mem_q[wr_addr_i] <= '1;
      else            mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i;
    end
    if (rd_en_i) rd_q <= mem_q[rd_addr_i];
  end

  // program count per word, saturates at 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) cnt_q[i] <= '0;
    end else if (wr_en_i) begin
      if (wr_erase_i)                    cnt_q[wr_addr_i] <= '0;
      else if (cnt_q[wr_addr_i] != 2'd2) cnt_q[wr_addr_i] <= cnt_q[wr_addr_i] + 2'd1;
    end
  end

  assign ovp_o     = wr_en_i && !wr_erase_i && (cnt_q[wr_addr_i] == 2'd2);
  assign rd_word_o = rd_q;
endmodule

// File: rtl/flash_bank_ctrl.sv
module flash_bank_ctrl
  import flash_bank_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_WORDS = 512,
  parameter int MAX_BURST  = 32,
  parameter int OP_CYCLES  = 16,
  localparam int WORDS = PAGES * PAGE_WORDS,
  localparam int AW    = $clog2(WORDS),
  localparam int LW    = $clog2(MAX_BURST),
  localparam int SW    = $clog2(OP_CYCLES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic [1:0]              cmd_op_i,
  input  logic [AW-1:0]           cmd_addr_i,
  input  logic [LW-1:0]           cmd_len_i,
  input  logic [32*MAX_BURST-1:0] cmd_wdata_i,
  output logic                    busy_o,
  output logic                    wr_en_o,
  output logic                    wr_erase_o,
  output logic [AW-1:0]           wr_addr_o,
  output logic [31:0]             wr_data_o
);
  localparam logic [AW-1:0] PAGE_MASK = AW'(PAGE_WORDS - 1);
  localparam logic [SW-1:0] SETTLE_LD = SW'(OP_CYCLES - 1);

  fb_state_e     state_q;
  logic [1:0]    op_q;
  logic [AW-1:0] base_q, last_q, idx_q;
  logic [SW-1:0] settle_q;
  logic [31:0]   buf_q [MAX_BURST];
  logic          accept;

  assign accept = cmd_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_NONE;
      base_q   <= '0;
      last_q   <= '0;
      idx_q    <= '0;
      settle_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q  <= cmd_op_i;
          idx_q <= '0;
          case (cmd_op_i)
            OP_ERASE_PAGE: begin
              base_q  <= cmd_addr_i & ~PAGE_MASK;
              last_q  <= PAGE_MASK;
              state_q <= ST_SWEEP;
            end
            OP_ERASE_BANK: begin
              base_q  <= '0;
              last_q  <= '1;
              state_q <= ST_SWEEP;
            end
            OP_PROGRAM: begin
              base_q  <= cmd_addr_i;
              last_q  <= AW'(cmd_len_i);
              state_q <= ST_SWEEP;
            end
            default: begin
              settle_q <= SETTLE_LD;
              state_q  <= ST_SETTLE;
            end
          endcase
        end
        ST_SWEEP: begin
          if (idx_q == last_q) begin
            settle_q <= SETTLE_LD;
            state_q  <= ST_SETTLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_q == '0) state_q <= ST_IDLE;
          else                settle_q <= settle_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // program data captured whole at accept
  always_ff @(posedge clk_i) begin
    if (accept) begin
      for (int i = 0; i < MAX_BURST; i++) buf_q[i] <= cmd_wdata_i[32*i +: 32];
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign wr_en_o    = (state_q == ST_SWEEP);
  assign wr_erase_o = (op_q != OP_PROGRAM);
  assign wr_addr_o  = base_q + idx_q;
  assign wr_data_o  = buf_q[idx_q[LW-1:0]];
endmodule

// File: rtl/flash_bank_rdport.sv
module flash_bank_rdport
  import flash_bank_pkg::*;
#(
  parameter int AW = 11,
  localparam int BAW = AW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_req_i,
  input  logic           busy_i,
  input  logic [BAW-1:0] rd_addr_i,
  input  logic [1:0]     rd_size_i,
  output logic           rd_ready_o,
  output logic           arr_rd_en_o,
  output logic [AW-1:0]  arr_rd_addr_o,
  input  logic [31:0]    arr_word_i,
  output logic           rd_valid_o,
  output logic [31:0]    rd_rdata_o
);
  logic       valid_q;
  logic [1:0] size_q, lane_q, lane_d;
  logic [31:0] shifted;

  assign rd_ready_o    = !busy_i;
  assign arr_rd_en_o   = rd_req_i && !busy_i;
  assign arr_rd_addr_o = rd_addr_i[BAW-1:2];

  always_comb begin
    case (rd_size_i)
      SZ_BYTE: lane_d = rd_addr_i[1:0];
      SZ_HALF: lane_d = {rd_addr_i[1], 1'b0};
      default: lane_d = 2'b00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      size_q  <= '0;
      lane_q  <= '0;
    end else begin
      valid_q <= arr_rd_en_o;
      if (arr_rd_en_o) begin
        size_q <= rd_size_i;
        lane_q <= lane_d;
      end
    end
  end

  assign shifted = arr_word_i >> {lane_q, 3'b000};

  always_comb begin
    case (size_q)
      SZ_BYTE: rd_rdata_o = {24'h0, shifted[7:0]};
      SZ_HALF: rd_rdata_o = {16'h0, shifted[15:0]};
      default: rd_rdata_o = shifted;
    endcase
  end

  assign rd_valid_o = valid_q;
endmodule

// File: rtl/flash_bank_model.sv
module flash_bank_model
  import flash_bank_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_WORDS = 512,
  parameter int MAX_BURST  = 32,
  parameter int OP_CYCLES  = 16,
  localparam int WORDS = PAGES * PAGE_WORDS,
  localparam int AW    = $clog2(WORDS),
  localparam int LW    = $clog2(MAX_BURST)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  output logic                    cmd_ready_o,
  input  logic [1:0]              cmd_op_i,
  input  logic [AW-1:0]           cmd_addr_i,
  input  logic [LW-1:0]           cmd_len_i,
  input  logic [32*MAX_BURST-1:0] cmd_wdata_i,
  output logic                    busy_o,
  output logic                    warn_o,
  input  logic                    rd_req_i,
  output logic                    rd_ready_o,
  input  logic [AW+1:0]           rd_addr_i,
  input  logic [1:0]              rd_size_i,
  output logic                    rd_valid_o,
  output logic [31:0]             rd_rdata_o
);
  logic          wr_en, wr_erase, ovp, arr_rd_en;
  logic [AW-1:0] wr_addr, arr_rd_addr;
  logic [31:0]   wr_data, arr_word;
  logic          warn_q;

  flash_bank_ctrl #(
    .PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS), .MAX_BURST(MAX_BURST), .OP_CYCLES(OP_CYCLES)
  ) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_addr_i, .cmd_len_i, .cmd_wdata_i,
    .busy_o,
    .wr_en_o(wr_en), .wr_erase_o(wr_erase), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  flash_bank_array #(.WORDS(WORDS)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_erase_i(wr_erase), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(arr_rd_en), .rd_addr_i(arr_rd_addr), .rd_word_o(arr_word), .ovp_o(ovp)
  );

  flash_bank_rdport #(.AW(AW)) u_rdport (
    .clk_i, .rst_ni, .rd_req_i, .busy_i(busy_o), .rd_addr_i, .rd_size_i,
    .rd_ready_o, .arr_rd_en_o(arr_rd_en), .arr_rd_addr_o(arr_rd_addr),
    .arr_word_i(arr_word), .rd_valid_o, .rd_rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  warn_q <= 1'b0;
    else if (ovp) warn_q <= 1'b1;
  end

  assign warn_o      = warn_q;
  assign cmd_ready_o = !busy_o;
endmodule

// File: rtl/flash_bank_model_chk.sv
module flash_bank_model_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        cmd_ready_o,
  input logic        busy_o,
  input logic        warn_o,
  input logic        rd_req_i,
  input logic        rd_ready_o,
  input logic [1:0]  rd_size_i,
  input logic        rd_valid_o,
  input logic [31:0] rd_rdata_o
);
  a_r6_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> busy_o);

  a_r7_no_data_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> !rd_valid_o);

  a_r7_valid_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_ready_o) |=> rd_valid_o);

  a_r8_byte_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_size_i) == 2'd0) |-> (rd_rdata_o[31:8] == 24'h0));

  a_r8_half_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_size_i) == 2'd1) |-> (rd_rdata_o[31:16] == 16'h0));

  a_r9_warn_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |=> warn_o);
endmodule

bind flash_bank_model flash_bank_model_chk u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .busy_o, .warn_o,
  .rd_req_i, .rd_ready_o, .rd_size_i, .rd_valid_o, .rd_rdata_o
);

// File: tb/flash_bank_model_bench.sv
module flash_bank_model_bench;
  localparam int PAGES = 4, PAGE_WORDS = 8, MAX_BURST = 4, OP_CYCLES = 3;
  localparam int AW = $clog2(PAGES * PAGE_WORDS);
  localparam int LW = $clog2(MAX_BURST);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0, cmd_ready_o;
  logic [1:0] cmd_op_i = '0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [LW-1:0] cmd_len_i = '0;
  logic [32*MAX_BURST-1:0] cmd_wdata_i = '0;
  logic busy_o, warn_o;
  logic rd_req_i = 1'b0, rd_ready_o;
  logic [AW+1:0] rd_addr_i = '0;
  logic [1:0] rd_size_i = '0;
  logic rd_valid_o;
  logic [31:0] rd_rdata_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  flash_bank_model #(
    .PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS), .MAX_BURST(MAX_BURST), .OP_CYCLES(OP_CYCLES)
  ) u_flash_bank_model (.*);

  // word address, program data, expected readback
  localparam logic [31:0] VEC [6][3] = '{
    '{32'd3,  32'hF0F0F0F0, 32'hF0F0F0F0},
    '{32'd3,  32'h0FFF00FF, 32'h00F000F0},
    '{32'd5,  32'h12345678, 32'h12345678},
    '{32'd5,  32'hFFFFFFFF, 32'h12345678},
    '{32'd9,  32'hA5A55A5A, 32'hA5A55A5A},
    '{32'd17, 32'hCAFEF00D, 32'hCAFEF00D}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // entered and left at a falling edge; returns busy length
  task automatic issue(input logic [1:0] op, input int addr, input int len,
                       input logic [127:0] data, output int busy_len);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_addr_i  = AW'(addr);
    cmd_len_i   = LW'(len);
    cmd_wdata_i = data;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    busy_len = 0;
    while (busy_o) begin
      busy_len++;
      @(negedge clk_i);
    end
  endtask

  task automatic rd(input int baddr, input logic [1:0] size, output logic [31:0] data);
    rd_req_i  = 1'b1;
    rd_addr_i = (AW+2)'(baddr);
    rd_size_i = size;
    @(negedge clk_i);
    rd_req_i = 1'b0;
    chk("R7", "read valid", {31'h0, rd_valid_o}, 32'h1);
    data = rd_rdata_o;
  endtask

  initial begin
    int n;
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "busy", {31'h0, busy_o}, 32'h0);
    chk("R1", "cmd_ready", {31'h0, cmd_ready_o}, 32'h1);
    chk("R1", "rd_ready", {31'h0, rd_ready_o}, 32'h1);
    chk("R1", "warn", {31'h0, warn_o}, 32'h0);
    chk("R1", "rd_valid", {31'h0, rd_valid_o}, 32'h0);

    issue(2'd1, 0, 0, '0, n);
    chk("R6", "bank erase busy cycles", n, PAGES * PAGE_WORDS + OP_CYCLES);
    rd(0, 2'd2, d);   chk("R3", "word 0 erased", d, 32'hFFFFFFFF);
    rd(124, 2'd2, d); chk("R3", "word 31 erased", d, 32'hFFFFFFFF);

    for (int i = 0; i < 6; i++) begin
      issue(2'd2, int'(VEC[i][0]), 0, {96'h0, VEC[i][1]}, n);
      chk("R6", "single program busy", n, 1 + OP_CYCLES);
      rd(int'(VEC[i][0]) * 4, 2'd2, d);
      chk("R4", $sformatf("vector %0d readback", i), d, VEC[i][2]);
    end
    chk("R9", "no warn after two programs", {31'h0, warn_o}, 32'h0);

    rd(21, 2'd0, d); chk("R8", "byte lane 1", d, 32'h56);
    rd(23, 2'd0, d); chk("R8", "byte lane 3", d, 32'h12);
    rd(20, 2'd1, d); chk("R8", "low half", d, 32'h5678);
    rd(23, 2'd1, d); chk("R8", "half aligned down", d, 32'h1234);
    rd(21, 2'd3, d); chk("R8", "word aligned down", d, 32'h12345678);

    issue(2'd2, 12, 2, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111}, n);
    chk("R6", "burst busy", n, 3 + OP_CYCLES);
    rd(48, 2'd2, d); chk("R5", "burst word 0", d, 32'h11111111);
    rd(52, 2'd2, d); chk("R5", "burst word 1", d, 32'h22222222);
    rd(56, 2'd2, d); chk("R5", "burst word 2", d, 32'h33333333);
    rd(60, 2'd2, d); chk("R5", "word past run untouched", d, 32'hFFFFFFFF);

    issue(2'd0, 13, 0, '0, n);
    chk("R6", "page erase busy", n, PAGE_WORDS + OP_CYCLES);
    rd(36, 2'd2, d); chk("R2", "page 1 word 9", d, 32'hFFFFFFFF);
    rd(48, 2'd2, d); chk("R2", "page 1 word 12", d, 32'hFFFFFFFF);
    rd(56, 2'd2, d); chk("R2", "page 1 word 14", d, 32'hFFFFFFFF);
    rd(20, 2'd2, d); chk("R2", "page 0 kept", d, 32'h12345678);
    rd(68, 2'd2, d); chk("R2", "page 2 kept", d, 32'hCAFEF00D);

    issue(2'd2, 9, 0, {96'h0, 32'hFFFF0000}, n);
    issue(2'd2, 9, 0, {96'h0, 32'hFF00FF00}, n);
    chk("R9", "erase cleared count", {31'h0, warn_o}, 32'h0);
    rd(36, 2'd2, d); chk("R4", "word 9 after two programs", d, 32'hFF000000);

    issue(2'd2, 3, 0, {96'h0, 32'hFFFFFFFF}, n);
    chk("R9", "third program warns", {31'h0, warn_o}, 32'h1);
    issue(2'd1, 0, 0, '0, n);
    chk("R9", "warn sticky across erase", {31'h0, warn_o}, 32'h1);

    // read held across a program
    cmd_valid_i = 1'b1; cmd_op_i = 2'd2; cmd_addr_i = AW'(20); cmd_len_i = '0;
    cmd_wdata_i = {96'h0, 32'h0000FFFF};
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    rd_req_i = 1'b1; rd_addr_i = (AW+2)'(80); rd_size_i = 2'd2;
    n = 0;
    while (busy_o) begin
      n++;
      if (rd_ready_o !== 1'b0) chk("R7", "rd_ready while busy", {31'h0, rd_ready_o}, 32'h0);
      if (rd_valid_o !== 1'b0) chk("R7", "rd_valid while busy", {31'h0, rd_valid_o}, 32'h0);
      @(negedge clk_i);
    end
    chk("R7", "stall length", n, 1 + OP_CYCLES);
    chk("R7", "no data as busy drops", {31'h0, rd_valid_o}, 32'h0);
    @(negedge clk_i);
    rd_req_i = 1'b0;
    chk("R7", "held read answered", {31'h0, rd_valid_o}, 32'h1);
    chk("R7", "held read sees new data", rd_rdata_o, 32'h0000FFFF);

    rst_ni = 1'b0;
    #1;
    chk("R1", "warn cleared by reset", {31'h0, warn_o}, 32'h0);
    chk("R1", "busy low in reset", {31'h0, busy_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired actual=hung expected=idle");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule